// File: doc/BRIEF.md
# Stream Packet-End Escape Encoder

This block takes a packet stream of 64-bit words with a valid/ready handshake and an end-of-packet flag. It produces a plain stream of 64-bit words with only valid and ready, so that a link carrying no end-of-packet flag still delivers packet boundaries.

Each packet end is coded in-band around a reserved marker word, 64'hDEADBEEFFEEDCAFE. A packet's final word D leaves as three beats: the marker, a control word, then D. An input word that happens to equal the marker is also sent as three beats, so the receiver can tell it is data. The control word tells the two cases apart. When it ends a packet, its upper half carries a running 32-bit sum of the packet's earlier words.

Both sides follow the usual stream rules. A beat transfers on a clock edge where valid and ready are both high. Once the upstream raises valid, it must hold valid and the word steady until ready is seen. The block holds its output valid and word steady while out_ready is low. An ordinary word passes straight through in the same cycle, and its in_ready follows out_ready. During a three-beat sequence, in_ready stays low until the last beat of the sequence is accepted downstream.

Top module: `tesc_encoder`

## Requirements
- R1: A valid input word with in_last low that is not the marker appears unchanged on out_data with out_valid high in the same cycle, and in_ready equals out_ready.
- R2: A final word D (in_last high, D not the marker) is emitted as three beats: the marker, a control word whose low 32 bits are 1, then D.
- R3: A non-final input word equal to the marker is emitted as three beats: the marker, a control word equal to zero (low half 0, upper half 0), then the marker.
- R4: A final input word equal to the marker is emitted as three beats: the marker, a control word with low half 1, then the marker.
- R5: In a control word with low half 1, bits 63:32 hold the modulo-2^32 sum of bits 31:0 plus bits 63:32 of every earlier word of the same packet, including earlier words equal to the marker.
- R6: The running sum returns to zero after a packet's final word is consumed, on rst, and on a one-cycle clear pulse. The first packet after any of these carries a zero sum.
- R7: While a three-beat sequence is pending, in_ready is low until the third beat transfers. The input word is consumed in exactly the cycle in which its last output copy transfers.
- R8: While out_valid is high and out_ready is low, out_valid and out_data stay unchanged on the next cycle. No beat is dropped or duplicated under any stall pattern.
- R9: After reset with no input offered, out_valid is low and in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous clear of sequence state and running sum |
| in_data | input | 64 | Input word |
| in_valid | input | 1 | Input word offered |
| in_last | input | 1 | Input word ends its packet |
| in_ready | output | 1 | Input word accepted this cycle |
| out_data | output | 64 | Output word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Downstream accepts output word |

## Verification
Some rules are checked by the assertions on every cycle. These are: output stability under stall, in_ready staying low while a control beat is pending, each consumed input coinciding with an output transfer, the control word's low half being only 0 or 1, and an emulation control word being all zeros. Other properties need a reference model, so only the bench scenarios can show them. These are the exact three-beat order, the value of the running sum across packets of mixed content, its return to zero after clear, and the absence of lost or extra beats. The bench sweeps every placement of marker-valued words in packets of one to four words, under several valid and ready duty cycles.

// File: rtl/tesc_pkg.sv
package tesc_pkg;

  // Sequencer phases. The marker beat is sent from ST_PASS, so a
  // special word costs no extra bubble cycle.
  typedef enum logic [1:0] {
    ST_PASS = 2'd0,
    ST_CTRL = 2'd1,
    ST_DATA = 2'd2
  } tesc_state_e;

endpackage

// File: rtl/tesc_classify.sv
module tesc_classify #(
  parameter int              DATA_W   = 64,
  parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE
) (
  input  logic [DATA_W-1:0] data,
  input  logic              valid,
  input  logic              last,
  output logic              is_marker,
  output logic              needs_seq
);

  always_comb begin
    is_marker = (data == ESC_WORD);
    needs_seq = valid & (last | is_marker);
  end

endmodule

// File: rtl/tesc_csum.sv
module tesc_csum #(
  parameter int DATA_W = 64,
  parameter int SUM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic              last,
  input  logic [DATA_W-1:0] data,
  output logic [SUM_W-1:0]  sum
);

  localparam int NSEG = DATA_W / SUM_W;

  logic [SUM_W-1:0] part [NSEG+1];

  assign part[0] = sum;

  // Chain of adders, one per SUM_W-wide slice of the word.
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign part[g+1] = part[g] + data[g*SUM_W +: SUM_W];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sum <= '0;
    end else if (take) begin
      sum <= last ? '0 : part[NSEG];
    end
  end

endmodule

// File: rtl/tesc_seq.sv
module tesc_seq
  import tesc_pkg::*;
#(
  parameter int                DATA_W   = 64,
  parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 in_valid,
  input  logic                 in_last,
  input  logic                 needs_seq,
  input  logic [DATA_W/2-1:0]  sum,
  input  logic                 out_ready,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_data,
  output tesc_state_e          state
);

  localparam int HALF_W = DATA_W / 2;

  tesc_state_e       state_nx;
  logic [DATA_W-1:0] hold_ctrl;
  logic              marker_go;

  // The marker beat transfers: capture the control word for the next beat.
  assign marker_go = (state == ST_PASS) && needs_seq && out_ready;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state     <= ST_PASS;
      hold_ctrl <= '0;
    end else begin
      state <= state_nx;
      if (marker_go) begin
        if (in_last) begin
          hold_ctrl <= {sum, {(HALF_W-1){1'b0}}, 1'b1};
        end else begin
          hold_ctrl <= '0;
        end
      end
    end
  end

  always_comb begin
    state_nx  = state;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = in_data;
    unique case (state)
      ST_PASS: begin
        if (needs_seq) begin
          out_valid = 1'b1;
          out_data  = ESC_WORD;
          if (out_ready) state_nx = ST_CTRL;
        end else begin
          out_valid = in_valid;
          in_ready  = out_ready;
        end
      end
      ST_CTRL: begin
        out_valid = 1'b1;
        out_data  = hold_ctrl;
        if (out_ready) state_nx = ST_DATA;
      end
      ST_DATA: begin
        // The upstream still holds the special word, so the word on
        // in_data is its last copy.
        out_valid = in_valid;
        out_data  = in_data;
        in_ready  = out_ready;
        if (out_ready && in_valid) state_nx = ST_PASS;
      end
      default: state_nx = ST_PASS;
    endcase
  end

endmodule

// File: rtl/tesc_encoder.sv
module tesc_encoder
  import tesc_pkg::*;
#(
  parameter int                DATA_W   = 64,
  parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);

  localparam int HALF_W = DATA_W / 2;

  logic              is_marker;
  logic              needs_seq;
  logic [HALF_W-1:0] sum;
  logic              take;
  tesc_state_e       st;

  tesc_classify #(.DATA_W(DATA_W), .ESC_WORD(ESC_WORD)) u_class (
    .data      (in_data),
    .valid     (in_valid),
    .last      (in_last),
    .is_marker (is_marker),
    .needs_seq (needs_seq)
  );

  assign take = in_valid && in_ready;

  tesc_csum #(.DATA_W(DATA_W), .SUM_W(HALF_W)) u_sum (
    .clk   (clk),
    .rst   (rst),
    .clear (clear),
    .take  (take),
    .last  (in_last),
    .data  (in_data),
    .sum   (sum)
  );

  tesc_seq #(.DATA_W(DATA_W), .ESC_WORD(ESC_WORD)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .needs_seq (needs_seq),
    .sum       (sum),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .state     (st)
  );

endmodule

// File: rtl/tesc_encoder_chk.sv
module tesc_encoder_chk #(
  parameter int                DATA_W   = 64,
  parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE
) (
  input logic              clk,
  input logic              rst,
  input logic              clear,
  input logic [DATA_W-1:0] in_data,
  input logic              in_valid,
  input logic              in_last,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        st
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [1:0] S_PASS = 2'd0;
  localparam logic [1:0] S_CTRL = 2'd1;

  // R8: a stalled beat stays in place
  p_hold_r8: assert property (@(posedge clk) disable iff (rst || clear)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: no input taken while the control beat is pending
  p_ctrl_block_r7: assert property (@(posedge clk) disable iff (rst || clear)
    (st == S_CTRL) |-> !in_ready);

  // R7: a final word is never taken on the marker beat
  p_last_block_r7: assert property (@(posedge clk) disable iff (rst || clear)
    (st == S_PASS && in_valid && in_last) |-> !in_ready);

  // R7: consuming an input always coincides with an output transfer
  p_take_xfer_r7: assert property (@(posedge clk) disable iff (rst || clear)
    (in_valid && in_ready) |-> (out_valid && out_ready));

  // R2: a transferred marker beat is followed by a control beat
  p_marker_next_r2: assert property (@(posedge clk) disable iff (rst || clear)
    (st == S_PASS && out_valid && out_ready && out_data == ESC_WORD && !in_ready)
      |=> (st == S_CTRL && out_valid));

  // R2: control word low half is only ever 0 or 1
  p_ctrl_code_r2: assert property (@(posedge clk) disable iff (rst || clear)
    (st == S_CTRL) |-> (out_data[HALF_W-1:1] == '0));

  // R3: an emulation control word is all zeros
  p_emul_zero_r3: assert property (@(posedge clk) disable iff (rst || clear)
    (st == S_CTRL && out_data[0] == 1'b0) |-> (out_data == '0));

  // R1: ordinary words pass through in the same cycle
  p_pass_r1: assert property (@(posedge clk) disable iff (rst || clear)
    (st == S_PASS && in_valid && !in_last && in_data != ESC_WORD)
      |-> (out_valid && out_data == in_data && in_ready == out_ready));

endmodule

bind tesc_encoder tesc_encoder_chk #(.DATA_W(DATA_W), .ESC_WORD(ESC_WORD)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clear     (clear),
  .in_data   (in_data),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .in_ready  (in_ready),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .st        (st)
);

// File: tb/tb_tesc_encoder.sv
module tb_tesc_encoder;

  localparam int          CLK_PERIOD = 10;
  localparam int          MAX_CYC    = 150000;
  localparam logic [63:0] ESC        = 64'hDEADBEEFFEEDCAFE;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [63:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tesc_encoder dut (
    .clk(clk), .rst(rst), .clear(clear),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  logic [63:0] stim_d[$];
  logic        stim_l[$];
  logic [63:0] exp_d[$];
  logic        exp_c[$];
  string       exp_t[$];
  logic [31:0] ref_sum = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Reference encoder: expands one input word into expected output beats.
  task automatic add_word(input logic [63:0] d, input logic l);
    stim_d.push_back(d);
    stim_l.push_back(l);
    if (l || d == ESC) begin
      exp_d.push_back(ESC); exp_c.push_back(1'b0);
      exp_t.push_back(l ? "R2" : "R3");
      if (l) begin
        exp_d.push_back({ref_sum, 32'd1}); exp_c.push_back(1'b0);
        exp_t.push_back(ref_sum == 32'd0 ? "R6" : "R5");
      end else begin
        exp_d.push_back(64'd0); exp_c.push_back(1'b0); exp_t.push_back("R3");
      end
      exp_d.push_back(d); exp_c.push_back(1'b1);
      exp_t.push_back((l && d == ESC) ? "R4" : (l ? "R2" : "R3"));
    end else begin
      exp_d.push_back(d); exp_c.push_back(1'b1); exp_t.push_back("R1");
    end
    if (l) ref_sum = '0;
    else   ref_sum = ref_sum + d[31:0] + d[63:32];
  endtask

  task automatic run_phase(input int vpct, input int rpct);
    bit          pend = 1'b0;
    bit          pv = 1'b0;
    bit          pr = 1'b0;
    logic [63:0] pd = '0;
    bit          ofire, ifire;
    logic [63:0] e;
    logic        c;
    string       t;
    while ((stim_d.size() > 0 || exp_d.size() > 0) && cyc < MAX_CYC) begin
      @(negedge clk);
      cyc++;
      if (pend) begin in_valid = 1'b0; pend = 1'b0; end
      if (!in_valid && stim_d.size() > 0 && $urandom_range(99) < vpct) begin
        in_valid = 1'b1;
        in_data  = stim_d[0];
        in_last  = stim_l[0];
      end
      out_ready = ($urandom_range(99) < rpct);
      #1;
      if (pv && !pr)
        chk(out_valid && out_data == pd, "R8", "stalled beat changed", out_data, pd);
      ofire = out_valid && out_ready;
      ifire = in_valid && in_ready;
      if (ofire) begin
        if (exp_d.size() == 0) begin
          chk(1'b0, "R8", "extra beat", out_data, 64'd0);
        end else begin
          e = exp_d.pop_front(); c = exp_c.pop_front(); t = exp_t.pop_front();
          chk(out_data == e, t, "beat value", out_data, e);
          chk(ifire == c, "R7", "consume timing", {63'd0, ifire}, {63'd0, c});
        end
      end else if (ifire) begin
        chk(1'b0, "R7", "consume without beat", 64'd1, 64'd0);
      end
      if (ifire) begin
        void'(stim_d.pop_front());
        void'(stim_l.pop_front());
        pend = 1'b1;
      end
      pv = out_valid; pr = out_ready; pd = out_data;
    end
    @(negedge clk);
    if (pend) in_valid = 1'b0;
    out_ready = 1'b0;
  endtask

  initial begin
    int vp[4] = '{100, 100, 60, 80};
    int rp[4] = '{100, 50, 30, 90};
    repeat (3) @(negedge clk);
    out_ready = 1'b1;
    #1;
    // R9: idle state out of reset
    chk(out_valid == 1'b0, "R9", "out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk(in_ready == out_ready, "R9", "in_ready follows out_ready", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R9", "out_valid idle", {63'd0, out_valid}, 64'd0);

    // Sweep every marker placement in packets of 1..4 words, several duty cycles.
    for (int p = 0; p < 4; p++) begin
      for (int len = 1; len <= 4; len++) begin
        for (int m = 0; m < (1 << len); m++) begin
          for (int i = 0; i < len; i++) begin
            add_word(m[i] ? ESC : {$urandom(), $urandom()}, i == len - 1);
          end
        end
      end
      run_phase(vp[p], rp[p]);
    end

    // R6: clear wipes a partial running sum
    add_word(64'h0000_0005_0000_0007, 1'b0);
    add_word(64'h1111_0000_0000_2222, 1'b0);
    run_phase(100, 100);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    ref_sum = '0;
    add_word(64'h0123_4567_89AB_CDEF, 1'b1);
    run_phase(100, 100);

    if (cyc >= MAX_CYC) chk(1'b0, "R8", "watchdog expired", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule